// File: doc/BRIEF.md
# Ring Node Transfer Forwarder

This block is the transfer engine for one station on a one-way ring of nodes that keep a shared memory image. Each transfer arriving from the upstream neighbour carries the ID of the node that created it, a kind (memory data or interrupt command), an address and a data word. Transfers that pass the error check go into a small receive queue. The node writes their data into its local memory and passes them on to the downstream neighbour through a transmit queue. A transfer that returns to the node that created it has gone all the way round the ring, so the node removes it. Each removal also refreshes a flag that shows the ring is unbroken.

The local host writes into the same memory port. Host writes compete with ring traffic for a single slot per cycle, and the two sources take turns when both are waiting. A host write is stamped with the node's own ID and joins the outgoing stream between transfers that are passing through. The fill level of the transmit queue controls the host. At half full a status flag and an optional interrupt tell software to pause. At full, a host write is refused with a bus-error response and changes nothing.

Top module: `ring_node_fwd`

## Requirements
- R1: `st_node_id` always equals the static `node_id` input.
- R2: An accepted upstream transfer with `up_err`=0 and `up_src` different from `node_id` appears on the downstream port with the same source, kind, address and data. Transfers leave in the order they arrived.
- R3: An accepted upstream transfer with `up_err`=0 and `up_src` equal to `node_id` is neither forwarded nor written to memory. `st_ring_ok` is 1 in the cycle after it is accepted.
- R4: An accepted upstream transfer with `up_err`=1 is neither forwarded nor written to memory. `irq_err` is high for exactly the next cycle when `arm_err`=1, and stays low when `arm_err`=0.
- R5: A forwarded transfer of kind 0 (memory data) produces one memory write of its address and data. A forwarded transfer of kind 1 (interrupt command) produces no memory write.
- R6: A host write (`hst_wr`=1) that is granted while the transmit queue is not full gives `hst_ack` in that same cycle. It produces a memory write of `hst_addr`/`hst_data`, and a downstream transfer with source `node_id`, kind 0 and the same address and data.
- R7: A host write that is granted while the transmit queue is full gives `hst_berr` instead of `hst_ack`. It makes no memory write and queues no transfer.
- R8: When the receive queue holds a transfer, the transmit queue has room and `hst_wr` is high, grants alternate between the two sources on consecutive cycles.
- R9: `st_half` is 1 exactly when the transmit queue holds at least TXF_DEPTH/2 entries. `irq_half` equals `st_half` AND `arm_half`.
- R10: After the last self-originated removal, `st_ring_ok` stays 1 for `ring_to_limit` further cycles and then falls to 0.
- R11: `up_ready` is 0 while the receive queue is full, and an upstream transfer is taken only when `up_valid` and `up_ready` are both high.
- R12: During and right after reset, `dn_valid`, `st_half`, `st_ring_ok`, `irq_err`, `hst_ack` and `hst_berr` are 0 and `up_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| node_id | input | 8 | Static ID of this node |
| arm_half | input | 1 | Enables the half-full interrupt |
| arm_err | input | 1 | Enables the link-error interrupt |
| ring_to_limit | input | TO_W | Cycles without a returning transfer before the ring flag clears |
| up_valid | input | 1 | Upstream transfer present |
| up_ready | output | 1 | Receive queue can take a transfer |
| up_src | input | 8 | Originator ID of the upstream transfer |
| up_kind | input | 1 | 0 = memory data, 1 = interrupt command |
| up_addr | input | ADDR_W | Upstream transfer address |
| up_data | input | DATA_W | Upstream transfer data |
| up_err | input | 1 | Upstream transfer failed its error check |
| hst_wr | input | 1 | Host write request, held until answered |
| hst_addr | input | ADDR_W | Host write address |
| hst_data | input | DATA_W | Host write data |
| hst_ack | output | 1 | Host write accepted |
| hst_berr | output | 1 | Host write refused (bus error) |
| mem_we | output | 1 | Local memory write strobe |
| mem_addr | output | ADDR_W | Local memory write address |
| mem_data | output | DATA_W | Local memory write data |
| dn_valid | output | 1 | Downstream transfer present |
| dn_ready | input | 1 | Downstream link takes the transfer |
| dn_src | output | 8 | Originator ID of the downstream transfer |
| dn_kind | output | 1 | Kind of the downstream transfer |
| dn_addr | output | ADDR_W | Downstream transfer address |
| dn_data | output | DATA_W | Downstream transfer data |
| st_node_id | output | 8 | Node ID as seen by software |
| st_half | output | 1 | Transmit queue at least half full |
| st_ring_ok | output | 1 | Own transfers are returning round the ring |
| irq_half | output | 1 | Half-full interrupt |
| irq_err | output | 1 | One-cycle link-error interrupt |

## Verification
The bench builds the block with a 4-entry transmit queue, a 2-entry receive queue, 6-bit addresses and 8-bit data. With these sizes the half-full and full thresholds are reached after two and four host writes, and the receive queue runs full within a few cycles when ring traffic and host writes compete. The main sweep covers all 16 low originator IDs against a fixed node ID, each with both kinds and both error states, and the error interrupt armed on alternate IDs. An 8-bit timeout counter lets the bench place the ring-flag expiry on the exact cycle it expects.

// File: rtl/ring_node_pkg.sv
package ring_node_pkg;
  localparam int NODE_W = 8;

  typedef enum logic {
    KIND_DATA = 1'b0,
    KIND_IRQ  = 1'b1
  } xfer_kind_e;
endpackage

// File: rtl/rn_fifo.sv
module rn_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 4
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             push_i,
  input  logic [WIDTH-1:0]                 data_i,
  input  logic                             pop_i,
  output logic [WIDTH-1:0]                 data_o,
  output logic                             empty_o,
  output logic                             full_o,
  output logic [$clog2(DEPTH+1)-1:0]       count_o
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] FULLV = CNT_W'(DEPTH);

  logic [WIDTH-1:0] slot_q [DEPTH];
  logic [PTR_W-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             do_push, do_pop;

  always_comb begin
    do_push = push_i && (cnt_q != FULLV);
    do_pop  = pop_i && (cnt_q != '0);
    wr_d    = wr_q;
    rd_d    = rd_q;
    cnt_d   = cnt_q;
    if (do_push) wr_d = (wr_q == LAST) ? '0 : wr_q + 1'b1;
    if (do_pop)  rd_d = (rd_q == LAST) ? '0 : rd_q + 1'b1;
    if (do_push && !do_pop)      cnt_d = cnt_q + 1'b1;
    else if (do_pop && !do_push) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) slot_q[wr_q] <= data_i;
  end

  assign data_o  = slot_q[rd_q];
  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == FULLV);
  assign count_o = cnt_q;

  // R7: a full queue is never pushed without a pop in the same cycle
  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && !pop_i) |-> !full_o);
  // R2: the queue is never popped while empty
  assert_no_underflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pop_i |-> !empty_o);
endmodule

// File: rtl/rn_rr_arb.sv
module rn_rr_arb (
  input  logic clk,
  input  logic rst_n,
  input  logic req_rx,
  input  logic req_host,
  output logic gnt_rx,
  output logic gnt_host
);
  logic last_host_q, last_host_d;

  always_comb begin
    gnt_host    = req_host && (!req_rx || !last_host_q);
    gnt_rx      = req_rx && (!req_host || last_host_q);
    last_host_d = last_host_q;
    if (gnt_host)    last_host_d = 1'b1;
    else if (gnt_rx) last_host_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_host_q <= 1'b0;
    else        last_host_q <= last_host_d;
  end

  assert_rr_host_then_rx_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_rx && req_host && gnt_host) ##1 (req_rx && req_host) |-> gnt_rx);
  assert_rr_rx_then_host_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_rx && req_host && gnt_rx) ##1 (req_rx && req_host) |-> gnt_host);
endmodule

// File: rtl/rn_ring_mon.sv
module rn_ring_mon #(
  parameter int TO_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            strip_i,
  input  logic [TO_W-1:0] limit_i,
  output logic            ok_o
);
  logic            ok_q, ok_d;
  logic [TO_W-1:0] idle_q, idle_d;

  always_comb begin
    ok_d   = ok_q;
    idle_d = idle_q;
    if (strip_i) begin
      ok_d   = 1'b1;
      idle_d = '0;
    end else if (ok_q) begin
      if (idle_q == limit_i) ok_d = 1'b0;
      else                   idle_d = idle_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ok_q   <= 1'b0;
      idle_q <= '0;
    end else begin
      ok_q   <= ok_d;
      idle_q <= idle_d;
    end
  end

  assign ok_o = ok_q;

  assert_ring_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
    strip_i |=> ok_o);
  assert_ring_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ok_o && !strip_i && (idle_q != limit_i)) |=> ok_o);
endmodule

// File: rtl/ring_node_fwd.sv
module ring_node_fwd
  import ring_node_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 32,
  parameter int RXF_DEPTH = 4,
  parameter int TXF_DEPTH = 16,
  parameter int TO_W      = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [7:0]        node_id,
  input  logic              arm_half,
  input  logic              arm_err,
  input  logic [TO_W-1:0]   ring_to_limit,
  input  logic              up_valid,
  output logic              up_ready,
  input  logic [7:0]        up_src,
  input  logic              up_kind,
  input  logic [ADDR_W-1:0] up_addr,
  input  logic [DATA_W-1:0] up_data,
  input  logic              up_err,
  input  logic              hst_wr,
  input  logic [ADDR_W-1:0] hst_addr,
  input  logic [DATA_W-1:0] hst_data,
  output logic              hst_ack,
  output logic              hst_berr,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_data,
  output logic              dn_valid,
  input  logic              dn_ready,
  output logic [7:0]        dn_src,
  output logic              dn_kind,
  output logic [ADDR_W-1:0] dn_addr,
  output logic [DATA_W-1:0] dn_data,
  output logic [7:0]        st_node_id,
  output logic              st_half,
  output logic              st_ring_ok,
  output logic              irq_half,
  output logic              irq_err
);
  localparam int XF_W  = NODE_W + 1 + ADDR_W + DATA_W;
  localparam int RXC_W = $clog2(RXF_DEPTH + 1);
  localparam int TXC_W = $clog2(TXF_DEPTH + 1);
  localparam logic [TXC_W-1:0] HALF = TXC_W'(TXF_DEPTH / 2);

  // upstream intake
  logic             up_fire, is_own, err_drop, own_strip, rx_push;
  logic [XF_W-1:0]  rx_in, rx_head;
  logic             rx_empty, rx_full, rx_pop;
  logic [RXC_W-1:0] rx_cnt;

  // transmit side
  logic             tx_push, tx_pop, tx_empty, tx_full;
  logic [XF_W-1:0]  tx_in, tx_head;
  logic [TXC_W-1:0] tx_cnt;

  // arbitration
  logic             req_rx, gnt_rx, gnt_host;
  logic [7:0]       rx_src;
  xfer_kind_e       rx_kind;
  logic [ADDR_W-1:0] rx_addr;
  logic [DATA_W-1:0] rx_data;

  logic irq_err_q, irq_err_d;

  always_comb begin
    up_fire   = up_valid && up_ready;
    is_own    = (up_src == node_id);
    err_drop  = up_fire && up_err;
    own_strip = up_fire && !up_err && is_own;
    rx_push   = up_fire && !up_err && !is_own;
    rx_in     = {up_src, up_kind, up_addr, up_data};
  end

  assign up_ready = !rx_full;

  rn_fifo #(.WIDTH(XF_W), .DEPTH(RXF_DEPTH)) u_rxq (
    .clk    (clk),
    .rst_n  (rst_n),
    .push_i (rx_push),
    .data_i (rx_in),
    .pop_i  (rx_pop),
    .data_o (rx_head),
    .empty_o(rx_empty),
    .full_o (rx_full),
    .count_o(rx_cnt)
  );

  always_comb begin
    rx_src  = rx_head[XF_W-1 -: NODE_W];
    rx_kind = xfer_kind_e'(rx_head[ADDR_W+DATA_W]);
    rx_addr = rx_head[ADDR_W+DATA_W-1 -: ADDR_W];
    rx_data = rx_head[DATA_W-1:0];
  end

  assign req_rx = !rx_empty && !tx_full;

  rn_rr_arb u_arb (
    .clk     (clk),
    .rst_n   (rst_n),
    .req_rx  (req_rx),
    .req_host(hst_wr),
    .gnt_rx  (gnt_rx),
    .gnt_host(gnt_host)
  );

  always_comb begin
    rx_pop   = gnt_rx;
    hst_ack  = gnt_host && !tx_full;
    hst_berr = gnt_host && tx_full;
    tx_push  = gnt_rx || hst_ack;
    mem_we   = (gnt_rx && (rx_kind == KIND_DATA)) || hst_ack;
    if (gnt_rx) begin
      tx_in    = {rx_src, rx_kind, rx_addr, rx_data};
      mem_addr = rx_addr;
      mem_data = rx_data;
    end else begin
      tx_in    = {node_id, KIND_DATA, hst_addr, hst_data};
      mem_addr = hst_addr;
      mem_data = hst_data;
    end
  end

  rn_fifo #(.WIDTH(XF_W), .DEPTH(TXF_DEPTH)) u_txq (
    .clk    (clk),
    .rst_n  (rst_n),
    .push_i (tx_push),
    .data_i (tx_in),
    .pop_i  (tx_pop),
    .data_o (tx_head),
    .empty_o(tx_empty),
    .full_o (tx_full),
    .count_o(tx_cnt)
  );

  assign dn_valid = !tx_empty;
  assign tx_pop   = dn_valid && dn_ready;
  assign {dn_src, dn_kind, dn_addr, dn_data} = tx_head;

  assign st_node_id = node_id;
  assign st_half    = (tx_cnt >= HALF);
  assign irq_half   = st_half && arm_half;

  rn_ring_mon #(.TO_W(TO_W)) u_ring (
    .clk    (clk),
    .rst_n  (rst_n),
    .strip_i(own_strip),
    .limit_i(ring_to_limit),
    .ok_o   (st_ring_ok)
  );

  assign irq_err_d = err_drop && arm_err;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_err_q <= 1'b0;
    else        irq_err_q <= irq_err_d;
  end
  assign irq_err = irq_err_q;

  // R3 / R4: dropped transfers never enter the receive queue
  assert_drop_not_queued_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (up_fire && (up_err || is_own)) |=> (rx_cnt <= $past(rx_cnt)));
  assert_err_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (up_fire && up_err && arm_err) |=> irq_err);
  assert_berr_no_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    hst_berr |-> (!mem_we && !hst_ack));
  assert_berr_keeps_level_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (hst_berr && !tx_pop) |=> (tx_cnt == $past(tx_cnt)));
  assert_irq_mem_skip_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_rx && (rx_kind == KIND_IRQ)) |-> !mem_we);
endmodule

// File: tb/tb_ring_node_fwd.sv
`timescale 1ns/1ps
module tb_ring_node_fwd;
  localparam int AW = 6;
  localparam int DW = 8;
  localparam int TXD = 4;
  localparam int RXD = 2;
  localparam int TOW = 8;
  localparam int XW = 8 + 1 + AW + DW;
  localparam int MW = AW + DW;

  logic clk, rst_n;
  logic [7:0] node_id;
  logic arm_half, arm_err;
  logic [TOW-1:0] ring_to_limit;
  logic up_valid, up_ready, up_kind, up_err;
  logic [7:0] up_src;
  logic [AW-1:0] up_addr;
  logic [DW-1:0] up_data;
  logic hst_wr, hst_ack, hst_berr;
  logic [AW-1:0] hst_addr;
  logic [DW-1:0] hst_data;
  logic mem_we;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_data;
  logic dn_valid, dn_ready, dn_kind;
  logic [7:0] dn_src;
  logic [AW-1:0] dn_addr;
  logic [DW-1:0] dn_data;
  logic [7:0] st_node_id;
  logic st_half, st_ring_ok, irq_half, irq_err;

  ring_node_fwd #(.ADDR_W(AW), .DATA_W(DW), .RXF_DEPTH(RXD), .TXF_DEPTH(TXD), .TO_W(TOW)) dut (
    .clk(clk), .rst_n(rst_n), .node_id(node_id), .arm_half(arm_half), .arm_err(arm_err),
    .ring_to_limit(ring_to_limit), .up_valid(up_valid), .up_ready(up_ready), .up_src(up_src),
    .up_kind(up_kind), .up_addr(up_addr), .up_data(up_data), .up_err(up_err),
    .hst_wr(hst_wr), .hst_addr(hst_addr), .hst_data(hst_data), .hst_ack(hst_ack),
    .hst_berr(hst_berr), .mem_we(mem_we), .mem_addr(mem_addr), .mem_data(mem_data),
    .dn_valid(dn_valid), .dn_ready(dn_ready), .dn_src(dn_src), .dn_kind(dn_kind),
    .dn_addr(dn_addr), .dn_data(dn_data), .st_node_id(st_node_id), .st_half(st_half),
    .st_ring_ok(st_ring_ok), .irq_half(irq_half), .irq_err(irq_err)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int n_chk = 0;
  int n_fail = 0;
  bit sb_on = 1'b1;
  int own_dn = 0, other_dn = 0, mem_cnt = 0;
  logic [XW-1:0] exp_dn[$];
  logic [MW-1:0] exp_mem[$];

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  // scoreboard monitor, samples at the falling edge
  always @(negedge clk) begin
    if (rst_n) begin
      if (dn_valid && dn_ready) begin
        if (sb_on) begin
          if (exp_dn.size() == 0) chk(1'b0, "R2 unexpected downstream", {dn_src, dn_kind, dn_addr, dn_data}, 0);
          else begin
            logic [XW-1:0] e;
            e = exp_dn.pop_front();
            chk({dn_src, dn_kind, dn_addr, dn_data} == e, "R2 downstream transfer", {dn_src, dn_kind, dn_addr, dn_data}, e);
          end
        end else if (dn_src == node_id) own_dn++;
        else other_dn++;
      end
      if (mem_we) begin
        if (sb_on) begin
          if (exp_mem.size() == 0) chk(1'b0, "R5 unexpected memory write", {mem_addr, mem_data}, 0);
          else begin
            logic [MW-1:0] m;
            m = exp_mem.pop_front();
            chk({mem_addr, mem_data} == m, "R5 memory write", {mem_addr, mem_data}, m);
          end
        end else mem_cnt++;
      end
    end
  end

  task automatic send(input logic [7:0] s, input logic k, input logic [AW-1:0] a,
                      input logic [DW-1:0] d, input logic e);
    @(posedge clk); #1;
    if (!e && s != node_id) begin
      exp_dn.push_back({s, k, a, d});
      if (!k) exp_mem.push_back({a, d});
    end
    up_valid = 1'b1; up_src = s; up_kind = k; up_addr = a; up_data = d; up_err = e;
    @(negedge clk);
    chk(up_ready == 1'b1, "R11 ready when queue has room", up_ready, 1);
    @(posedge clk); #1;
    up_valid = 1'b0;
    @(negedge clk);
    chk(irq_err == (e && arm_err), "R4 error interrupt pulse", irq_err, e && arm_err);
    if (!e && s == node_id) chk(st_ring_ok == 1'b1, "R3 ring flag set on strip", st_ring_ok, 1);
  endtask

  task automatic host_write(input logic [AW-1:0] a, input logic [DW-1:0] d, input bit expect_ack);
    @(posedge clk); #1;
    if (expect_ack) begin
      exp_dn.push_back({node_id, 1'b0, a, d});
      exp_mem.push_back({a, d});
    end
    hst_wr = 1'b1; hst_addr = a; hst_data = d;
    @(negedge clk);
    if (expect_ack) chk(hst_ack && !hst_berr, "R6 host write acknowledged", {hst_ack, hst_berr}, 2'b10);
    else            chk(!hst_ack && hst_berr, "R7 host write bus error", {hst_ack, hst_berr}, 2'b01);
    @(posedge clk); #1;
    hst_wr = 1'b0;
  endtask

  initial begin
    #2_000_000;
    chk(1'b0, "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    rst_n = 1'b0; node_id = 8'd5; arm_half = 1'b1; arm_err = 1'b0; ring_to_limit = 8'd200;
    up_valid = 1'b0; up_src = '0; up_kind = 1'b0; up_addr = '0; up_data = '0; up_err = 1'b0;
    hst_wr = 1'b0; hst_addr = '0; hst_data = '0; dn_ready = 1'b1;
    repeat (3) @(negedge clk);
    // R12 reset state
    chk({dn_valid, st_half, st_ring_ok, irq_err, hst_ack, hst_berr} == 6'b0, "R12 reset outputs low",
        {dn_valid, st_half, st_ring_ok, irq_err, hst_ack, hst_berr}, 0);
    chk(up_ready == 1'b1, "R12 ready in reset", up_ready, 1);
    @(posedge clk); #1 rst_n = 1'b1;
    @(negedge clk);
    chk({dn_valid, st_half, st_ring_ok, irq_err} == 4'b0, "R12 state after reset", {dn_valid, st_half, st_ring_ok, irq_err}, 0);

    // R1 node id readback
    for (int i = 0; i < 256; i += 51) begin
      node_id = 8'(i); #1;
      chk(st_node_id == 8'(i), "R1 node id readback", st_node_id, i);
    end
    node_id = 8'd5;

    // R2 R3 R4 R5 sweep over source, kind and error flag
    for (int s = 0; s < 16; s++) begin
      for (int k = 0; k < 2; k++) begin
        for (int e = 0; e < 2; e++) begin
          arm_err = s[0];
          send(8'(s), k[0], AW'(s * 4 + k * 2 + e), DW'(s * 16 + k * 5 + e * 3 + 1), e[0]);
          repeat (3) @(negedge clk);
        end
      end
    end
    repeat (4) @(negedge clk);
    chk(exp_dn.size() == 0, "R2 all forwards seen", exp_dn.size(), 0);
    chk(exp_mem.size() == 0, "R5 all memory writes seen", exp_mem.size(), 0);

    // R6 R7 R9 fill the transmit queue with the link stalled
    dn_ready = 1'b0;
    for (int k = 1; k <= TXD; k++) begin
      host_write(AW'(40 + k), DW'(200 + k), 1'b1);
      @(negedge clk);
      chk(st_half == (k >= TXD / 2), "R9 half flag level", st_half, k >= TXD / 2);
      chk(irq_half == (k >= TXD / 2), "R9 half interrupt armed", irq_half, k >= TXD / 2);
    end
    arm_half = 1'b0; #1;
    chk(irq_half == 1'b0, "R9 half interrupt disarmed", irq_half, 0);
    host_write(AW'(60), DW'(99), 1'b0);
    @(negedge clk);
    chk(dn_valid == 1'b1, "R7 queue still holds data", dn_valid, 1);
    dn_ready = 1'b1;
    repeat (8) @(negedge clk);
    chk(exp_dn.size() == 0, "R6 host transfers sent downstream", exp_dn.size(), 0);
    chk(exp_mem.size() == 0, "R7 no write for refused host access", exp_mem.size(), 0);
    chk(st_half == 1'b0, "R9 half flag clears when drained", st_half, 0);

    // R10 ring timeout
    ring_to_limit = 8'd20;
    send(8'd5, 1'b0, AW'(1), DW'(2), 1'b0);
    repeat (20) @(posedge clk);
    @(negedge clk);
    chk(st_ring_ok == 1'b1, "R10 flag held through limit", st_ring_ok, 1);
    @(posedge clk); @(negedge clk);
    chk(st_ring_ok == 1'b0, "R10 flag cleared after limit", st_ring_ok, 0);

    // R8 R11 host and ring contend for the memory slot
    sb_on = 1'b0; own_dn = 0; other_dn = 0; mem_cnt = 0;
    begin
      int acks;
      bit saw_low;
      bit ackv[16];
      acks = 0; saw_low = 1'b0;
      fork
        begin
          @(posedge clk); #1;
          hst_wr = 1'b1; hst_addr = AW'(7); hst_data = DW'(70);
          for (int i = 0; i < 16; i++) begin
            @(negedge clk);
            ackv[i] = hst_ack;
            if (hst_ack) acks++;
          end
          @(posedge clk); #1;
          hst_wr = 1'b0;
        end
        begin
          @(posedge clk); #1;
          up_valid = 1'b1; up_src = 8'd9; up_kind = 1'b0; up_err = 1'b0; up_addr = AW'(30); up_data = DW'(0);
          for (int j = 0; j < 10; j++) begin
            @(negedge clk);
            while (!up_ready) begin
              saw_low = 1'b1;
              @(negedge clk);
            end
            @(posedge clk); #1;
            if (j == 9) up_valid = 1'b0;
            else begin
              up_addr = AW'(31 + j); up_data = DW'(j + 1);
            end
          end
        end
      join
      for (int i = 0; i < 14; i++)
        chk(ackv[i] == ((i % 2) == 0), "R8 grants alternate", ackv[i], (i % 2) == 0);
      repeat (30) @(negedge clk);
      chk(saw_low, "R11 ready dropped when receive queue full", saw_low, 1);
      chk(other_dn == 10, "R2 all ring transfers forwarded under contention", other_dn, 10);
      chk(own_dn == acks, "R6 every acknowledged host write sent", own_dn, acks);
      chk(mem_cnt == 10 + acks, "R5 memory writes under contention", mem_cnt, 10 + acks);
    end
    sb_on = 1'b1;
    finish_run();
  end
endmodule